// File: doc/BRIEF.md
# Sleep-Aware Command-Driven Output Register

This block holds the levels of nine digital control lines that switch external radio circuits. A command arrives as one strobed word made of three bytes. When the upper two bits of the middle byte mark it as an output command, it can load the eight low lines from the first byte, and it always loads the ninth line from one bit of the third byte. When the middle byte carries the control group code and the third byte carries a particular two-bit code, the command is a restart. A restart returns the block to the state it has after power-up.

Each line has its own parking behaviour in sleep. Some lines are pulled low, some are driven high, and some are released to high impedance through a per-line output enable. The block starts in sleep after reset or a restart, and any output command takes it out. An external sleep input can also force the parked levels at any time. The stored line values survive sleep, so the lines return to them when sleep ends.

Top module: `sleep_io_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the block is in sleep and all nine stored line values are 0. The stored zeros appear on the lines once an output command wakes the block without rewriting them.
- R2: An accepted command with middle byte bits [7:6] = 01 and middle byte bit 2 = 1 stores first-byte bits 7..0 into lines 7..0. The stored values are visible from the clock edge that accepts the command.
- R3: An output command whose middle byte bit 2 = 0 leaves lines 7..0 unchanged.
- R4: Every accepted output command (middle byte [7:6] = 01) stores third-byte bit 5 into line 8, whatever middle byte bit 2 holds.
- R5: Any accepted output command ends the sleep state entered through reset or restart.
- R6: An accepted command with middle byte [7:6] = 10 and third byte [1:0] = 11 restores the reset state of R1. A command with middle byte [7:6] = 10 and any other value of third byte [1:0] changes nothing.
- R7: While asleep (the internal state, or the sleep input high), lines 0, 1, 5, 6 and 7 drive 0 and lines 2 and 3 drive 1, all with output enable 1. Lines 4 and 8 have output enable 0 and data 0. The data word is therefore 0x00C and the enable word is 0x0EF.
- R8: Commands accepted while the sleep input is high still update the stored values. The stored values are kept through sleep and appear when the sleep input falls.
- R9: With the strobe low, no byte value changes the outputs.
- R10: Commands whose middle byte [7:6] is 00 or 11 change nothing and do not wake the block.
- R11: When awake, all nine output enables are 1 and each line drives its stored value, where 1 means high or on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on detector) |
| cmd_valid | input | 1 | Strobe: the three command bytes are valid this cycle |
| cmd_b0 | input | 8 | First command byte (line data) |
| cmd_b1 | input | 8 | Middle command byte (group code and enables) |
| cmd_b2 | input | 8 | Third command byte (line 8 data and restart code) |
| sleep_in | input | 1 | Forces parked levels while high |
| line_out | output | 9 | Data level of each line |
| line_oe | output | 9 | Output enable per line; 0 means high impedance |

## Verification
The bench targets the decode boundaries. These are the group codes 00 and 11, the control group with the wrong restart code, and an output command with the low-byte enable cleared. A loose decoder would either overwrite lines or wake the block on these commands. It also writes commands while the sleep input is high and then releases sleep. A design that blocked those writes, or that lost the stored values while parked, would show stale or zero lines at that point. After a restart and after a mid-run reset, the bench wakes the block without writing the low byte. Stored values that were not cleared would then appear on the lines.

// File: rtl/sleep_io_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the per-line sleep parking policy.
// Assumes one command word of three bytes and lines numbered from 0.
package sleep_io_pkg;
    localparam int BYTE_W     = 8;
    localparam int LINE_CNT   = BYTE_W + 1;
    // Field positions that the decoder depends on.
    localparam int GRP_MSB    = 7;
    localparam int GRP_LSB    = 6;
    localparam int LOWEN_BIT  = 2;
    localparam int TOPSRC_BIT = 5;
    localparam logic [1:0] GRP_OUTPUT = 2'b01;
    localparam logic [1:0] GRP_CTRL   = 2'b10;
    localparam logic [1:0] RESTART_CODE = 2'b11;

    typedef enum logic [1:0] {
        PARK_LOW  = 2'd0,
        PARK_HIGH = 2'd1,
        PARK_HIZ  = 2'd2
    } park_e;

    // Sleep parking level for line idx.
    function automatic park_e park_level(input int idx);
        case (idx)
            2, 3:    return PARK_HIGH;
            4, 8:    return PARK_HIZ;
            default: return PARK_LOW;
        endcase
    endfunction
endpackage

// File: rtl/sleep_io_decode.sv
`timescale 1ns/1ps
// Command decoder: classifies the strobed command word into load,
// wake and restart actions. Purely combinational; assumes the bytes
// are stable while cmd_valid is high.
module sleep_io_decode
    import sleep_io_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_b1,
    input  logic [W-1:0] cmd_b2,
    output logic         load_low,
    output logic         load_top,
    output logic         wake,
    output logic         restart
);
    logic [1:0] grp;

    // Pick the group code and derive the actions.
    always_comb begin
        grp      = cmd_b1[GRP_MSB:GRP_LSB];
        load_top = cmd_valid && (grp == GRP_OUTPUT);
        wake     = load_top;
        load_low = load_top && cmd_b1[LOWEN_BIT];
        restart  = cmd_valid && (grp == GRP_CTRL) && (cmd_b2[1:0] == RESTART_CODE);
    end
endmodule

// File: rtl/sleep_io_store.sv
`timescale 1ns/1ps
// Line store: holds the written line values and the sleep flag.
// Reset and restart both clear the values and set the flag.
// Assumes load and restart never coincide (distinct group codes).
module sleep_io_store
    import sleep_io_pkg::*;
#(
    parameter int W = BYTE_W,
    localparam int N = W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_low,
    input  logic         load_top,
    input  logic         wake,
    input  logic         restart,
    input  logic [W-1:0] low_data,
    input  logic         top_data,
    output logic [N-1:0] stored,
    output logic         asleep
);
    // Update the low lines on an enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            stored[W-1:0] <= '0;
        else if (load_low)
            stored[W-1:0] <= low_data;
    end

    // Update the top line on every output command.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            stored[N-1] <= 1'b0;
        else if (load_top)
            stored[N-1] <= top_data;
    end

    // Sleep flag: set by reset or restart, cleared by an output command.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            asleep <= 1'b1;
        else if (wake)
            asleep <= 1'b0;
    end
endmodule

// File: rtl/sleep_io_drive.sv
`timescale 1ns/1ps
// Line driver: chooses the stored value or the per-line parking level.
// Combinational; a high-impedance line drives data 0 with enable 0.
module sleep_io_drive
    import sleep_io_pkg::*;
#(
    parameter int N = LINE_CNT
) (
    input  logic         park,
    input  logic [N-1:0] stored,
    output logic [N-1:0] line_out,
    output logic [N-1:0] line_oe
);
    for (genvar i = 0; i < N; i++) begin : g_line
        localparam park_e LVL = park_level(i);
        if (LVL == PARK_HIZ) begin : g_hiz
            // Release the line while parked.
            always_comb begin
                line_out[i] = park ? 1'b0 : stored[i];
                line_oe[i]  = !park;
            end
        end else begin : g_drv
            // Drive the parking level while parked.
            always_comb begin
                line_out[i] = park ? (LVL == PARK_HIGH) : stored[i];
                line_oe[i]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sleep_io_ctrl.sv
`timescale 1ns/1ps
// Top: command-driven output register with per-line sleep parking.
// Assumes a synchronous active-low reset from the power-on detector
// and one command word per cycle when cmd_valid is high.
module sleep_io_ctrl
    import sleep_io_pkg::*;
#(
    parameter int W = BYTE_W,
    localparam int N = W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_b0,
    input  logic [W-1:0] cmd_b1,
    input  logic [W-1:0] cmd_b2,
    input  logic         sleep_in,
    output logic [N-1:0] line_out,
    output logic [N-1:0] line_oe
);
    logic         load_low, load_top, wake, restart, asleep;
    logic [N-1:0] stored;
    logic         park;

    sleep_io_decode #(.W(W)) u_dec (
        .cmd_valid(cmd_valid), .cmd_b1(cmd_b1), .cmd_b2(cmd_b2),
        .load_low(load_low), .load_top(load_top), .wake(wake), .restart(restart)
    );

    sleep_io_store #(.W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .load_low(load_low), .load_top(load_top),
        .wake(wake), .restart(restart), .low_data(cmd_b0),
        .top_data(cmd_b2[TOPSRC_BIT]), .stored(stored), .asleep(asleep)
    );

    // Parked when the internal flag or the external input asks for it.
    always_comb park = asleep || sleep_in;

    sleep_io_drive #(.N(N)) u_drv (
        .park(park), .stored(stored), .line_out(line_out), .line_oe(line_oe)
    );
endmodule

// File: rtl/sleep_io_ctrl_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of sleep_io_ctrl, bound below.
module sleep_io_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_b0,
    input logic [7:0] cmd_b1,
    input logic [7:0] cmd_b2,
    input logic       sleep_in,
    input logic [8:0] line_out,
    input logic [8:0] line_oe
);
    // R7: external sleep forces parked levels.
    a_r7_parked_levels: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_in |-> (line_out == 9'h00C && line_oe == 9'h0EF));

    // R6: restart returns to the parked reset state.
    a_r6_restart_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_b1 & 8'hC0) == 8'h80 && (cmd_b2 & 8'h03) == 8'h03)
        |=> (line_out == 9'h00C && line_oe == 9'h0EF));

    // R5 / R11: an output command wakes the block with all enables on.
    a_r5_wake_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_b1 & 8'hC0) == 8'h40) |=> (sleep_in || line_oe == 9'h1FF));

    // R2: enabled write shows the first byte on lines 7..0.
    a_r2_low_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_b1 & 8'hC4) == 8'h44)
        |=> (sleep_in || line_out[7:0] == $past(cmd_b0)));

    // R4: line 8 follows third byte bit 5.
    a_r4_top_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_b1 & 8'hC0) == 8'h40)
        |=> (sleep_in || line_out[8] == $past(cmd_b2[5])));

    // R9: without a strobe and with sleep held low, outputs hold.
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !sleep_in) |=> (sleep_in || ($stable(line_out) && $stable(line_oe))));
endmodule

bind sleep_io_ctrl sleep_io_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_b0(cmd_b0),
    .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .sleep_in(sleep_in),
    .line_out(line_out), .line_oe(line_oe)
);

// File: tb/sleep_io_ctrl_test.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset checks.
module sleep_io_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_b0 = '0, cmd_b1 = '0, cmd_b2 = '0;
    logic       sleep_in = 1'b0;
    logic [8:0] line_out, line_oe;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [8:0] PK_D = 9'h00C;
    localparam logic [8:0] PK_E = 9'h0EF;
    localparam logic [8:0] ON_E = 9'h1FF;

    always #2.5 clk = ~clk;

    sleep_io_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_b0(cmd_b0),
        .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .sleep_in(sleep_in),
        .line_out(line_out), .line_oe(line_oe)
    );

    // {valid, sleep, b0, b1, b2, expected data, expected enable}
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, PK_D,   PK_E},  // R9 idle stays asleep
        {1'b1, 1'b0, 8'hFF, 8'h04, 8'h20, PK_D,   PK_E},  // R10 group 00
        {1'b1, 1'b0, 8'hFF, 8'hC4, 8'h20, PK_D,   PK_E},  // R10 group 11
        {1'b1, 1'b0, 8'hA5, 8'h44, 8'h20, 9'h1A5, ON_E},  // R2 R4 R5 wake+load
        {1'b1, 1'b0, 8'hFF, 8'h40, 8'h00, 9'h0A5, ON_E},  // R3 low held, R4
        {1'b1, 1'b0, 8'h3C, 8'h7F, 8'hDF, 9'h03C, ON_E},  // R2 R11
        {1'b0, 1'b0, 8'hFF, 8'h44, 8'h20, 9'h03C, ON_E},  // R9 no strobe
        {1'b0, 1'b1, 8'h00, 8'h00, 8'h00, PK_D,   PK_E},  // R7 sleep input
        {1'b1, 1'b1, 8'h81, 8'h44, 8'h20, PK_D,   PK_E},  // R8 write while parked
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 9'h181, ON_E},  // R8 values restored
        {1'b1, 1'b0, 8'hFF, 8'h80, 8'h02, 9'h181, ON_E},  // R6 wrong restart code
        {1'b1, 1'b0, 8'hFF, 8'hBF, 8'hFF, PK_D,   PK_E},  // R6 restart
        {1'b1, 1'b0, 8'hFF, 8'h40, 8'h00, 9'h000, ON_E},  // R1 R6 cleared on wake
        {1'b1, 1'b0, 8'h5A, 8'h44, 8'h20, 9'h15A, ON_E}   // R2 R4
    };

    task automatic check(input string req, input logic [8:0] exp_d, input logic [8:0] exp_e);
        checks++;
        if (line_out !== exp_d || line_oe !== exp_e) begin
            errors++;
            $display("FAIL %s: data %h en %h, expected data %h en %h",
                     req, line_out, line_oe, exp_d, exp_e);
        end
    endtask

    task automatic apply(input logic v, input logic s, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [7:0] b2);
        @(negedge clk);
        cmd_valid = v; sleep_in = s; cmd_b0 = b0; cmd_b1 = b1; cmd_b2 = b2;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset parks", PK_D, PK_E);
        check("R7 reset levels", PK_D, PK_E);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][43], VEC[i][42], VEC[i][41:34], VEC[i][33:26], VEC[i][25:18]);
            check($sformatf("vector %0d", i), VEC[i][17:9], VEC[i][8:0]);
        end

        // R1: mid-run reset parks and clears stored values.
        @(negedge clk);
        cmd_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", PK_D, PK_E);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 1'b0, 8'hFF, 8'h40, 8'h00);
        check("R1 stored cleared", 9'h000, ON_E);

        // R7 with high stored values: parked levels override.
        apply(1'b1, 1'b0, 8'hFF, 8'h44, 8'h20);
        check("R11 all high", 9'h1FF, ON_E);
        apply(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R7 park over ones", PK_D, PK_E);
        apply(1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        check("R8 ones restored", 9'h1FF, ON_E);

        // R10: group 00 with the enable bit does not write.
        apply(1'b1, 1'b0, 8'h00, 8'h04, 8'h00);
        check("R10 group 00 no write", 9'h1FF, ON_E);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule